// File: doc/BRIEF.md
# Memory-to-memory copy DMA engine

The block copies a contiguous run of bytes from one region of memory to another over a memory-mapped bus. Software writes a source address, a destination address and a byte count into separate registers. It then writes a control word that selects the beat width, chooses single-beat or burst operation and sets the start bit. Read data passes through an internal FIFO to the write side. In burst mode both the read and the write side issue multi-beat bursts. Each burst is cut so that it never runs past the remaining count or the FIFO room.

Burst operation is only defined at the full bus width. A start request that pairs bursting with a narrower width is refused without touching the bus. A start request that asks for a width wider than the bus is also refused. The engine finishes when the remaining count reaches zero, and it never issues a beat once the count is zero. If the stop-at-zero option is off, the engine stays busy at zero until software writes the control word with the start bit clear.

Register word addresses: 0 status, 1 control, 2 byte count, 3 source address, 4 destination address.

Top module: `mm_copy_dma`

## Requirements
- R1: After reset, status (address 0) and control (address 1) read zero, and neither the read nor the write request is asserted.
- R2: The control word has these fields: width code in bits [2:0] (0 byte, 1 halfword, 2 word, 3 doubleword, 4 quadword), burst enable in bit 3, stop-at-zero in bit 4 and start in bit 5. Starting with burst enable set and a width code other than the full bus width (2 for a 32-bit bus) is refused, as is starting with any width code above the bus width. A refused start issues no bus request and leaves status at DONE=1 (bit 0), BUSY=0 (bit 1), ERR=1 (bit 2).
- R3: For every legal width, after DONE the destination bytes equal the source bytes over the programmed count, and no destination byte outside that span is written.
- R4: In burst mode each read and write burst count is the smallest of 32, the beats still due and the FIFO room. A 40-word copy therefore issues a 32-beat burst followed by an 8-beat burst on each side.
- R5: In single mode every request has a burst count of 1. The byte enables equal the width's lane mask shifted by the low address bits, so narrow copies between differently aligned addresses place each byte correctly.
- R6: The byte count register falls by the width for every accepted write beat and reads zero at the end. The source address register advances by the programmed count.
- R7: No write beat is issued while the byte count is zero. A copy of N bytes at width W produces exactly N/W write beats.
- R8: DONE is set, and BUSY cleared, only after the last write beat has been accepted and the FIFO and all outstanding reads are empty.
- R9: Any write to the status register clears DONE and ERR.
- R10: A start with a count of zero and stop-at-zero set ends with DONE and no bus request.
- R11: With stop-at-zero clear, the engine stays BUSY after the count reaches zero. It sets DONE only when the control word is written with the start bit clear.
- R12: FIFO entries plus outstanding read beats never exceed 128. With the write side stalled, exactly 128 read beats are fetched.
- R13: A read or write request held off by its wait input keeps its request, address and burst count unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register word address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational on csr_addr |
| rd_req | output | 1 | Read burst request |
| rd_addr | output | 32 | Read burst start address |
| rd_burst | output | 6 | Read burst beat count |
| rd_wait | input | 1 | Read request held off |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | 32 | Read data beat |
| wr_req | output | 1 | Write beat request |
| wr_addr | output | 32 | Write burst start address, held for the whole burst |
| wr_burst | output | 6 | Write burst beat count |
| wr_data | output | 32 | Write data beat |
| wr_be | output | 4 | Write byte enables |
| wr_wait | input | 1 | Write beat held off |

## Verification
Register reads are combinational, so the bench writes registers on the falling edge and reads back one time step later. A refused start is visible in status at the edge that takes the control write. A zero-count start shows DONE two edges after that write. DONE for a real copy appears one edge after the final write beat is accepted, so the bench polls status once per cycle within a bounded window and only then compares destination memory, the count and the address registers. Burst sizes, byte enables and out-of-span writes are logged by the bus models at the accepting edge, and those logs are checked after DONE.

// File: rtl/mm_copy_dma.sv
module mm_copy_dma #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int LW = 26,
  parameter int MAXB = 32,
  parameter int DEPTH = 128
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    csr_we,
  input  logic [2:0]              csr_addr,
  input  logic [31:0]             csr_wdata,
  output logic [31:0]             csr_rdata,
  output logic                    rd_req,
  output logic [AW-1:0]           rd_addr,
  output logic [$clog2(MAXB):0]   rd_burst,
  input  logic                    rd_wait,
  input  logic                    rd_valid,
  input  logic [DW-1:0]           rd_data,
  output logic                    wr_req,
  output logic [AW-1:0]           wr_addr,
  output logic [$clog2(MAXB):0]   wr_burst,
  output logic [DW-1:0]           wr_data,
  output logic [DW/8-1:0]         wr_be,
  input  logic                    wr_wait
);
  localparam int NB   = DW / 8;
  localparam int LB   = $clog2(NB);
  localparam int BCW  = $clog2(MAXB) + 1;
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = PW + 1;
  localparam int XW   = LW + 1;
  localparam int FULLW = LB;
  localparam int B_BM = 3;
  localparam int B_ZS = 4;
  localparam int B_GO = 5;

  logic [2:0]      wsel;
  logic            bmode, zstop, busy, done, err;
  logic [LW-1:0]   len_q, rd_left;
  logic [AW-1:0]   src_q, dst_q, rd_addr_q, wr_addr_q;
  logic [CW-1:0]   cnt, pend;
  logic [PW-1:0]   wp, rp;
  logic [LB-1:0]   ret_lane;
  logic [DW-1:0]   mem [DEPTH];
  logic            rd_req_q, wr_act;
  logic [BCW-1:0]  rd_burst_q, wr_burst_q, wr_k;

  function automatic logic [XW-1:0] mn(input logic [XW-1:0] a, input logic [XW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [XW-1:0] nbeats(input logic [LW-1:0] n, input logic [2:0] w);
    return (XW'(n) + (XW'(1) << w) - XW'(1)) >> w;
  endfunction

  function automatic logic [LW-1:0] dec(input logic [LW-1:0] n, input logic [XW-1:0] d);
    return (XW'(n) > d) ? LW'(XW'(n) - d) : '0;
  endfunction

  logic [XW-1:0] wb, cap, room, rd_n, wr_need;
  logic rd_issue, wr_start, wr_beat, push, pop, ctl_wr, illegal, quiet, finish;

  assign wb       = XW'(1) << wsel;
  assign cap      = bmode ? XW'(MAXB) : XW'(1);
  assign room     = XW'(DEPTH) - XW'(cnt) - XW'(pend);
  assign rd_n     = mn(mn(cap, nbeats(rd_left, wsel)), room);
  assign wr_need  = mn(cap, nbeats(len_q, wsel));
  assign rd_issue = busy && !rd_req_q && (rd_left != '0) && (room != '0);
  assign wr_start = busy && !wr_act && (len_q != '0) && (XW'(cnt) >= wr_need);
  assign wr_beat  = wr_act && !wr_wait;
  assign push     = rd_valid;
  assign pop      = wr_beat;
  assign ctl_wr   = csr_we && (csr_addr == 3'd1);
  assign illegal  = (csr_wdata[2:0] > 3'(FULLW)) ||
                    (csr_wdata[B_BM] && (csr_wdata[2:0] != 3'(FULLW)));
  assign quiet    = !wr_act && !rd_req_q && (cnt == '0) && (pend == '0);
  assign finish   = busy && (len_q == '0) && quiet &&
                    (zstop || (ctl_wr && !csr_wdata[B_GO]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsel <= '0; bmode <= 1'b0; zstop <= 1'b0;
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      len_q <= '0; rd_left <= '0; src_q <= '0; dst_q <= '0;
      rd_addr_q <= '0; wr_addr_q <= '0;
      cnt <= '0; pend <= '0; wp <= '0; rp <= '0; ret_lane <= '0;
      rd_req_q <= 1'b0; wr_act <= 1'b0;
      rd_burst_q <= '0; wr_burst_q <= '0; wr_k <= '0;
    end else begin
      if (csr_we && !busy) begin
        case (csr_addr)
          3'd2: len_q <= csr_wdata[LW-1:0];
          3'd3: src_q <= AW'(csr_wdata);
          3'd4: dst_q <= AW'(csr_wdata);
          default: ;
        endcase
      end
      if (csr_we && csr_addr == 3'd0) begin
        done <= 1'b0;
        err  <= 1'b0;
      end
      if (ctl_wr && !busy) begin
        wsel  <= csr_wdata[2:0];
        bmode <= csr_wdata[B_BM];
        zstop <= csr_wdata[B_ZS];
        if (csr_wdata[B_GO]) begin
          if (illegal) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            busy     <= 1'b1;
            done     <= 1'b0;
            err      <= 1'b0;
            rd_left  <= len_q;
            ret_lane <= src_q[LB-1:0];
          end
        end
      end
      if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
      end

      if (rd_issue) begin
        rd_req_q   <= 1'b1;
        rd_burst_q <= BCW'(rd_n);
        rd_addr_q  <= src_q;
        src_q      <= src_q + AW'(rd_n << wsel);
        rd_left    <= dec(rd_left, rd_n << wsel);
      end else if (rd_req_q && !rd_wait) begin
        rd_req_q <= 1'b0;
      end
      pend <= pend + (rd_issue ? CW'(rd_n) : '0) - CW'(push);
      cnt  <= cnt + CW'(push) - CW'(pop);
      if (push) begin
        wp       <= wp + 1'b1;
        ret_lane <= ret_lane + LB'(wb);
      end

      if (wr_start) begin
        wr_act     <= 1'b1;
        wr_burst_q <= BCW'(wr_need);
        wr_k       <= BCW'(wr_need);
        wr_addr_q  <= dst_q;
      end
      if (wr_beat) begin
        rp    <= rp + 1'b1;
        dst_q <= dst_q + AW'(wb);
        len_q <= dec(len_q, wb);
        wr_k  <= wr_k - 1'b1;
        if (wr_k == BCW'(1)) wr_act <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= rd_data >> {ret_lane, 3'b000};
  end

  logic [2*NB-1:0] lane_mask;
  assign lane_mask = ((2*NB)'(1) << wb) - (2*NB)'(1);

  assign rd_req   = rd_req_q;
  assign rd_addr  = rd_addr_q;
  assign rd_burst = rd_burst_q;
  assign wr_req   = wr_act;
  assign wr_addr  = wr_addr_q;
  assign wr_burst = wr_burst_q;
  assign wr_data  = mem[rp] << {dst_q[LB-1:0], 3'b000};
  assign wr_be    = lane_mask[NB-1:0] << dst_q[LB-1:0];

  always_comb begin
    case (csr_addr)
      3'd0:    csr_rdata = {29'b0, err, busy, done};
      3'd1:    csr_rdata = {26'b0, busy, zstop, bmode, wsel};
      3'd2:    csr_rdata = 32'(len_q);
      3'd3:    csr_rdata = 32'(src_q);
      3'd4:    csr_rdata = 32'(dst_q);
      default: csr_rdata = '0;
    endcase
  end
endmodule

module mm_copy_dma_chk #(
  parameter int AW = 32,
  parameter int LW = 26,
  parameter int MAXB = 32,
  parameter int DEPTH = 128,
  parameter int CW = 8,
  parameter int BCW = 6
)(
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic           bmode,
  input logic [LW-1:0]  len_q,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  pend,
  input logic           rd_req,
  input logic           rd_wait,
  input logic [AW-1:0]  rd_addr,
  input logic [BCW-1:0] rd_burst,
  input logic           wr_req,
  input logic           wr_wait,
  input logic [AW-1:0]  wr_addr,
  input logic [BCW-1:0] wr_burst
);
  // R12
  fifo_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) + 32'(pend)) <= DEPTH);
  // R4
  rd_burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_burst != '0) && (32'(rd_burst) <= MAXB));
  // R4
  wr_burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_burst != '0) && (32'(wr_burst) <= MAXB));
  // R5
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !bmode) |-> (rd_burst == BCW'(1)));
  // R7
  no_beat_past_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (len_q != '0));
  // R8
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done && (cnt == '0) && (pend == '0) && !wr_req && !rd_req);
  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !busy);
  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_wait) |=> rd_req && $stable(rd_addr) && $stable(rd_burst));
  // R13
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_wait) |=> wr_req && $stable(wr_addr) && $stable(wr_burst));
endmodule

bind mm_copy_dma mm_copy_dma_chk #(
  .AW(AW), .LW(LW), .MAXB(MAXB), .DEPTH(DEPTH), .CW(CW), .BCW(BCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err), .bmode(bmode),
  .len_q(len_q), .cnt(cnt), .pend(pend),
  .rd_req(rd_req), .rd_wait(rd_wait), .rd_addr(rd_addr), .rd_burst(rd_burst),
  .wr_req(wr_req), .wr_wait(wr_wait), .wr_addr(wr_addr), .wr_burst(wr_burst)
);

// File: tb/mm_copy_dma_tb.sv
module mm_copy_dma_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_we;
  logic [2:0]  csr_addr;
  logic [31:0] csr_wdata, csr_rdata;
  logic        rd_req, rd_wait, rd_valid;
  logic [31:0] rd_addr, rd_data;
  logic [5:0]  rd_burst, wr_burst;
  logic        wr_req, wr_wait;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_copy_dma u_dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_burst(rd_burst), .rd_wait(rd_wait),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_burst(wr_burst), .wr_data(wr_data),
    .wr_be(wr_be), .wr_wait(wr_wait)
  );

  int n_chk = 0, n_bad = 0;
  logic rd_hold = 1'b0, wr_stall = 1'b0, clr = 1'b0;
  int cur_wb = 4, cur_dst = 0, cur_len = 0;

  function automatic logic [7:0] sb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = sb(a + 32'(i));
    return w;
  endfunction

  // read-side memory model
  int ret_cnt, rbeats, rb_n;
  logic [31:0] ret_addr;
  logic [5:0] rb_log [8];
  assign rd_wait = rd_hold || (ret_cnt != 0);

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      ret_cnt <= 0; rd_valid <= 1'b0; rbeats <= 0; rb_n <= 0; rd_data <= '0; ret_addr <= '0;
    end else begin
      if (ret_cnt != 0) begin
        rd_valid <= 1'b1; rd_data <= word_at(ret_addr);
        ret_addr <= ret_addr + 32'd4; ret_cnt <= ret_cnt - 1; rbeats <= rbeats + 1;
      end else rd_valid <= 1'b0;
      if (rd_req && !rd_wait) begin
        ret_cnt <= int'(rd_burst); ret_addr <= {rd_addr[31:2], 2'b00};
        if (rb_n < 8) rb_log[rb_n[2:0]] <= rd_burst;
        rb_n <= rb_n + 1;
      end
    end
  end

  // write-side memory model
  logic [7:0] dmem [2048];
  int widx, wbeats, wb_n, bad_be, oob, maxb;
  logic [31:0] wbase;
  logic [5:0] wb_log [8];
  assign wr_wait = wr_stall;

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      widx <= 0; wbeats <= 0; wb_n <= 0; bad_be <= 0; oob <= 0; maxb <= 0; wbase <= '0;
      if (clr) for (int i = 0; i < 2048; i++) dmem[i] <= 8'hEE;
    end else if (wr_req && !wr_wait) begin : wbeat
      logic [31:0] a;
      logic [3:0] eb;
      a = ((widx == 0) ? wr_addr : wbase) + 32'(widx) * 32'd4;
      eb = 4'((((32'd1 << cur_wb) - 32'd1) << a[1:0]) & 32'hF);
      if (widx == 0) begin
        wbase <= wr_addr;
        if (wb_n < 8) wb_log[wb_n[2:0]] <= wr_burst;
        wb_n <= wb_n + 1;
        if (int'(wr_burst) > maxb) maxb <= int'(wr_burst);
      end
      widx <= (widx + 1 == int'(wr_burst)) ? 0 : widx + 1;
      if (wr_be !== eb) bad_be <= bad_be + 1;
      for (int i = 0; i < 4; i++) begin
        if (wr_be[i]) begin
          if (int'({a[31:2], 2'b00}) + i < cur_dst || int'({a[31:2], 2'b00}) + i >= cur_dst + cur_len)
            oob <= oob + 1;
          else
            dmem[{a[10:2], 2'b00} + 11'(i)] <= wr_data[8*i +: 8];
        end
      end
      wbeats <= wbeats + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic start(input int src, input int dst, input int len, input logic [5:0] ctl);
    cur_wb = 1 << ctl[2:0]; cur_dst = dst; cur_len = len;
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    csr_write(3'd1, 32'd0);
    csr_write(3'd0, 32'd0);
    csr_write(3'd2, 32'(len));
    csr_write(3'd3, 32'(src));
    csr_write(3'd4, 32'(dst));
    csr_write(3'd1, {26'b0, ctl});
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 5000; i++) begin
      csr_read(3'd0, st);
      if (st[0]) break;
    end
  endtask

  // {src, dst, len, width code, burst}
  localparam logic [43:0] VEC [6] = '{
    {16'h0400, 12'h000, 12'd160, 3'd2, 1'b1},
    {16'h1230, 12'h200, 12'd8,   3'd2, 1'b1},
    {16'h0800, 12'h100, 12'd20,  3'd2, 1'b0},
    {16'h0102, 12'h306, 12'd12,  3'd1, 1'b0},
    {16'h0201, 12'h403, 12'd9,   3'd0, 1'b0},
    {16'h2000, 12'h500, 12'd520, 3'd2, 1'b1}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] st, v2;
    rst_n = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    csr_read(3'd0, st); check("R1 status", st, 32'd0);
    csr_read(3'd1, st); check("R1 control", st, 32'd0);
    check("R1 requests", {30'b0, rd_req, wr_req}, 32'd0);

    for (int v = 0; v < 6; v++) begin
      int src, dst, len, w, bm, errs, outside;
      src = int'(VEC[v][43:28]); dst = int'(VEC[v][27:16]); len = int'(VEC[v][15:4]);
      w = int'(VEC[v][3:1]); bm = int'(VEC[v][0]);
      start(src, dst, len, {1'b1, 1'b1, 1'(bm), 3'(w)});
      wait_done(st);
      check("R8 status done", st, 32'd1);
      check("R7 write beats", 32'(wbeats), 32'(len >> w));
      check("R7 out-of-span writes", 32'(oob), 32'd0);
      errs = 0; outside = 0;
      for (int k = 0; k < len; k++) if (dmem[dst + k] !== sb(32'(src + k))) errs++;
      for (int i = 0; i < 2048; i++)
        if ((i < dst || i >= dst + len) && dmem[i] !== 8'hEE) outside++;
      check("R3 copied bytes", 32'(errs), 32'd0);
      check("R3 untouched bytes", 32'(outside), 32'd0);
      csr_read(3'd2, st); check("R6 count zero", st, 32'd0);
      csr_read(3'd3, st); check("R6 source advanced", st, 32'(src + len));
      check("R5 byte enables", 32'(bad_be), 32'd0);
      check("R4 max burst", 32'(maxb), bm ? ((len >> w) < 32 ? 32'(len >> w) : 32'd32) : 32'd1);
      if (v == 0) begin
        check("R4 read burst 1", 32'(rb_log[0]), 32'd32);
        check("R4 read burst 2", 32'(rb_log[1]), 32'd8);
        check("R4 write burst 1", 32'(wb_log[0]), 32'd32);
        check("R4 write burst 2", 32'(wb_log[1]), 32'd8);
      end
    end

    // R2 burst with byte width refused
    start(16'h0400, 0, 64, 6'b111000);
    repeat (20) @(negedge clk);
    csr_read(3'd0, st); check("R2 burst+byte status", st, 32'd5);
    check("R2 no reads", 32'(rb_n), 32'd0);
    // R9 status write clears DONE and ERR
    csr_write(3'd0, 32'd0);
    csr_read(3'd0, st); check("R9 cleared", st, 32'd0);
    // R2 quadword on a 32-bit bus refused
    start(16'h0400, 0, 64, 6'b110100);
    repeat (20) @(negedge clk);
    csr_read(3'd0, st); check("R2 quad status", st, 32'd5);
    check("R2 no writes", 32'(wb_n), 32'd0);

    // R10 zero count
    start(16'h0400, 0, 0, 6'b110010);
    repeat (5) @(negedge clk);
    csr_read(3'd0, st); check("R10 status", st, 32'd1);
    check("R10 no requests", 32'(rb_n + wb_n), 32'd0);

    // R11 stop-at-zero clear
    start(16'h0600, 12'h100, 64, 6'b101010);
    repeat (300) @(negedge clk);
    csr_read(3'd0, st); check("R11 still busy", st, 32'd2);
    csr_read(3'd2, st); check("R11 count zero", st, 32'd0);
    check("R11 beats", 32'(wbeats), 32'd16);
    csr_write(3'd1, 32'h0000000A);
    csr_read(3'd0, st); check("R11 done after clear", st, 32'd1);

    // R12 writer stalled
    wr_stall = 1'b1;
    start(16'h0900, 12'h100, 800, 6'b111010);
    repeat (400) @(negedge clk);
    check("R12 read beats", 32'(rbeats), 32'd128);
    csr_read(3'd0, st); check("R12 busy", st, 32'd2);
    csr_read(3'd2, st); check("R6 count untouched", st, 32'd800);
    wr_stall = 1'b0;
    wait_done(st);
    check("R12 done", st, 32'd1);
    check("R12 write beats", 32'(wbeats), 32'd200);

    // R13 read request held under wait
    rd_hold = 1'b1;
    start(16'h0A00, 12'h100, 16, 6'b110010);
    repeat (5) @(negedge clk);
    #1 st = rd_addr;
    repeat (3) @(negedge clk);
    #1 v2 = rd_addr;
    check("R13 request held", {31'b0, rd_req}, 32'd1);
    check("R13 address stable", v2, st);
    check("R13 burst", 32'(rd_burst), 32'd1);
    rd_hold = 1'b0;
    wait_done(st);
    check("R13 done", st, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule